// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This unit resolves conditional branches for a single-cycle datapath and holds the program counter. A comparator looks at the two register operands and raises an equality flag and a less-than flag. It can compare them either as signed or as unsigned values. It does not use the ALU. This leaves the ALU free to add the decoded branch offset to the current PC in the same cycle, and that sum reaches the unit on a plain input.

The control logic reads the comparator flags and the three-bit branch condition code. From them it produces the ALU operand-A select and the PC source select. It also forces the register-write and memory-write enables low while a branch is in flight. The PC register loads the selected next-PC value on every rising clock edge, and a synchronous reset returns it to a parameterised vector.

All pins are plain control or status signals that are sampled each cycle. There is no stream traffic, so no valid/ready handshake applies and there is no back-pressure.

Top module: `branch_nextpc_unit`

## Requirements
- R1: `br_eq` is 1 exactly when `rs1_val` equals `rs2_val`.
- R2: `br_lt` is 1 when `rs1_val` is below `rs2_val`. The comparison is unsigned when `br_un` is 1 and two's-complement signed otherwise. `br_un` equals bit 1 of `cond`, so it is 1 for codes 110 and 111.
- R3: `a_sel` is 1 (PC to ALU operand A) whenever `is_branch` is 1. Otherwise `a_sel` follows `dec_a_sel`.
- R4: With `is_branch` high, the branch is taken according to `cond`:
  - 000 is taken on equal.
  - 001 is taken on not equal.
  - 100 and 110 are taken on less than.
  - 101 and 111 are taken on not less than.
  - A taken branch drives `pc_sel` to 1 and `next_pc` to `alu_sum`.
- R5: A branch that is not taken, or any cycle with `is_branch` low, drives `pc_sel` to 0 and `next_pc` to `pc + 4`.
- R6: `reg_wen` and `mem_wen` are 0 while `is_branch` is 1. Otherwise they follow `dec_reg_wen` and `dec_mem_wen`.
- R7: On every rising clock edge outside reset, `pc` takes the `next_pc` value of the previous cycle.
- R8: A synchronous reset sets `pc` to `RESET_VEC`, which defaults to 0x00000000.
- R9: The unused codes 010 and 011 with `is_branch` high are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| is_branch | input | 1 | Current instruction is a conditional branch |
| cond | input | 3 | Branch condition code |
| rs1_val | input | 32 | First register operand |
| rs2_val | input | 32 | Second register operand |
| alu_sum | input | 32 | ALU result (pc + offset for branches) |
| dec_a_sel | input | 1 | Operand-A select from main decode |
| dec_reg_wen | input | 1 | Register write enable from main decode |
| dec_mem_wen | input | 1 | Memory write enable from main decode |
| br_eq | output | 1 | Operands equal |
| br_lt | output | 1 | rs1 below rs2 |
| br_un | output | 1 | Unsigned compare in use |
| a_sel | output | 1 | ALU operand A: 1 = pc, 0 = rs1 |
| pc_sel | output | 1 | PC source: 1 = alu_sum, 0 = pc + 4 |
| reg_wen | output | 1 | Gated register write enable |
| mem_wen | output | 1 | Gated memory write enable |
| next_pc | output | 32 | Value that pc loads at the next edge |
| pc | output | 32 | Program counter |

## Verification
Resolving a branch and writing the PC fall in the same cycle. The comparator flags set `pc_sel`, and the edge that closes that cycle loads either the target or pc + 4. The bench provokes this with back-to-back branches. Each one uses an `alu_sum` built from the live `pc` and a random offset, with random operands plus equal operands and the values 0x7FFFFFFF and 0x80000000. It judges the combinational `next_pc` before the edge and the registered `pc` after it against a reference function.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic [2:0] {
    C_EQ   = 3'b000,
    C_NE   = 3'b001,
    C_RSV2 = 3'b010,
    C_RSV3 = 3'b011,
    C_LT   = 3'b100,
    C_GE   = 3'b101,
    C_LTU  = 3'b110,
    C_GEU  = 3'b111
  } cond_e;
endpackage

// File: rtl/br_compare.sv
module br_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         uns,
  output logic         eq,
  output logic         lt
);
  // Extend each operand by one bit: a sign copy for signed, zero for unsigned.
  logic [W:0] ax, bx;
  always_comb begin
    ax = {a[W-1] & ~uns, a};
    bx = {b[W-1] & ~uns, b};
    eq = (a == b);
    lt = ($signed(ax) < $signed(bx));
  end
endmodule

// File: rtl/br_control.sv
module br_control
  import br_pkg::*;
(
  input  logic       is_branch,
  input  logic [2:0] cond,
  input  logic       eq,
  input  logic       lt,
  input  logic       dec_a_sel,
  input  logic       dec_reg_wen,
  input  logic       dec_mem_wen,
  output logic       uns,
  output logic       a_sel,
  output logic       pc_sel,
  output logic       reg_wen,
  output logic       mem_wen
);
  logic taken;
  always_comb begin
    uns = cond[1];
    unique case (cond_e'(cond))
      C_EQ:         taken = eq;
      C_NE:         taken = ~eq;
      C_LT, C_LTU:  taken = lt;
      C_GE, C_GEU:  taken = ~lt;
      default:      taken = 1'b0;
    endcase
    pc_sel  = is_branch & taken;
    a_sel   = is_branch | dec_a_sel;
    reg_wen = dec_reg_wen & ~is_branch;
    mem_wen = dec_mem_wen & ~is_branch;
  end

  always_comb begin
    if (is_branch) assert_branch_no_write_R6: assert (!reg_wen && !mem_wen);
  end
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int          W         = 32,
  parameter logic [W-1:0] RESET_VEC = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VEC;
    else     q <= d;
  end

  assert_reset_vec_R8: assert property (@(posedge clk) rst |=> q == RESET_VEC);
endmodule

// File: rtl/branch_nextpc_unit.sv
module branch_nextpc_unit #(
  parameter int           XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = '0,
  parameter int           INSN_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            is_branch,
  input  logic [2:0]      cond,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] alu_sum,
  input  logic            dec_a_sel,
  input  logic            dec_reg_wen,
  input  logic            dec_mem_wen,
  output logic            br_eq,
  output logic            br_lt,
  output logic            br_un,
  output logic            a_sel,
  output logic            pc_sel,
  output logic            reg_wen,
  output logic            mem_wen,
  output logic [XLEN-1:0] next_pc,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

  logic [XLEN-1:0] pc_plus;

  br_compare #(.W(XLEN)) u_cmp (
    .a(rs1_val), .b(rs2_val), .uns(br_un), .eq(br_eq), .lt(br_lt)
  );

  br_control u_ctl (
    .is_branch(is_branch), .cond(cond), .eq(br_eq), .lt(br_lt),
    .dec_a_sel(dec_a_sel), .dec_reg_wen(dec_reg_wen), .dec_mem_wen(dec_mem_wen),
    .uns(br_un), .a_sel(a_sel), .pc_sel(pc_sel),
    .reg_wen(reg_wen), .mem_wen(mem_wen)
  );

  always_comb begin
    pc_plus = pc + STEP;
    next_pc = pc_sel ? alu_sum : pc_plus;
  end

  pc_reg #(.W(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
    .clk(clk), .rst(rst), .d(next_pc), .q(pc)
  );

  assert_flags_exclusive_R1: assert property (@(posedge clk) disable iff (rst)
    br_eq |-> !br_lt);
  assert_branch_asel_R3: assert property (@(posedge clk) disable iff (rst)
    is_branch |-> a_sel);
  assert_nonbranch_seq_R5: assert property (@(posedge clk) disable iff (rst)
    !is_branch |-> !pc_sel);
  assert_reserved_not_taken_R9: assert property (@(posedge clk) disable iff (rst)
    (is_branch && cond[2:1] == 2'b01) |-> !pc_sel);
  assert_pc_load_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc == ($past(pc_sel) ? $past(alu_sum) : $past(pc) + STEP));
endmodule

// File: tb/branch_nextpc_unit_bench.sv
module branch_nextpc_unit_bench;
  localparam int W = 32;
  localparam logic [W-1:0] RV = 32'h0000_0000;

  logic clk = 0, rst = 1;
  logic is_branch = 0, dec_a_sel = 0, dec_reg_wen = 0, dec_mem_wen = 0;
  logic [2:0] cond = 0;
  logic [W-1:0] rs1_val = 0, rs2_val = 0, alu_sum = 0;
  logic br_eq, br_lt, br_un, a_sel, pc_sel, reg_wen, mem_wen;
  logic [W-1:0] next_pc, pc;

  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  branch_nextpc_unit #(.XLEN(W), .RESET_VEC(RV)) u_branch_nextpc_unit (
    .clk, .rst, .is_branch, .cond, .rs1_val, .rs2_val, .alu_sum,
    .dec_a_sel, .dec_reg_wen, .dec_mem_wen, .br_eq, .br_lt, .br_un,
    .a_sel, .pc_sel, .reg_wen, .mem_wen, .next_pc, .pc
  );

  function automatic bit ref_taken(input logic [2:0] c, input logic [W-1:0] a, b);
    case (c)
      3'b000: return a == b;
      3'b001: return a != b;
      3'b100: return $signed(a) < $signed(b);
      3'b101: return !($signed(a) < $signed(b));
      3'b110: return a < b;
      3'b111: return !(a < b);
      default: return 0;
    endcase
  endfunction

  function automatic bit ref_lt(input logic [2:0] c, input logic [W-1:0] a, b);
    return c[1] ? (a < b) : ($signed(a) < $signed(b));
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one instruction at the falling edge, checks before and after the edge.
  task automatic step(input bit br, input logic [2:0] c, input logic [W-1:0] a, b,
                      input logic [W-1:0] off, input bit da, dr, dm);
    logic [W-1:0] exp_next;
    bit tk;
    @(negedge clk);
    is_branch = br; cond = c; rs1_val = a; rs2_val = b;
    dec_a_sel = da; dec_reg_wen = dr; dec_mem_wen = dm;
    alu_sum = pc + off;
    #1;
    tk = br && ref_taken(c, a, b);
    exp_next = tk ? pc + off : pc + 32'd4;
    chk("R1 br_eq", W'(br_eq), W'(a == b));
    chk("R2 br_lt", W'(br_lt), W'(ref_lt(c, a, b)));
    chk("R3 a_sel", W'(a_sel), W'(br | da));
    if (br) begin
      if (c[2:1] == 2'b01) chk("R9 reserved pc_sel", W'(pc_sel), 0);
      else chk("R4 next_pc", next_pc, exp_next);
    end else chk("R5 next_pc", next_pc, exp_next);
    chk("R6 reg_wen", W'(reg_wen), W'(dr & ~br));
    chk("R6 mem_wen", W'(mem_wen), W'(dm & ~br));
    @(posedge clk); #1;
    chk("R7 pc load", pc, exp_next);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1 chk("R8 reset pc", pc, RV);
    @(negedge clk) rst = 0;
    // directed corners
    step(1, 3'b000, 32'd5, 32'd5, 32'h100, 0, 1, 1);
    step(1, 3'b001, 32'd5, 32'd5, 32'h100, 0, 1, 0);
    step(1, 3'b100, 32'h8000_0000, 32'h7FFF_FFFF, 32'h40, 0, 0, 1);
    step(1, 3'b110, 32'h8000_0000, 32'h7FFF_FFFF, 32'h40, 0, 0, 0);
    step(1, 3'b101, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFF0, 0, 0, 0);
    step(1, 3'b111, 32'h7FFF_FFFF, 32'h8000_0000, 32'h20, 0, 0, 0);
    step(1, 3'b010, 32'd1, 32'd1, 32'h80, 0, 1, 1);
    step(1, 3'b011, 32'd1, 32'd2, 32'h80, 0, 1, 1);
    step(0, 3'b000, 32'd7, 32'd7, 32'h80, 1, 1, 1);
    // constrained random
    for (int i = 0; i < 400; i++) begin
      logic [2:0] c;
      logic [W-1:0] a, b;
      int sel;
      c = 3'($urandom);
      sel = int'($urandom % 8);
      a = $urandom;
      b = (sel == 0) ? a : (sel == 1) ? 32'h7FFF_FFFF : (sel == 2) ? 32'h8000_0000 : $urandom;
      if (sel == 3) a = 32'h8000_0000;
      step(($urandom % 4) != 0, c, a, b, {$urandom} & 32'hFFFF_FFFE & 32'h0000_1FFE | (($urandom % 2) ? 32'hFFFF_E000 : 0),
           1'($urandom), 1'($urandom), 1'($urandom));
    end
    // reset mid-run
    @(negedge clk) rst = 1;
    @(posedge clk); #1 chk("R8 sync reset", pc, RV);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule